// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit sits behind the SPI front end of a serial memory and decides whether a write may proceed. It holds the status byte (protect-enable, the two block-protect bits, the write-enable latch and a ready/busy flag) and the write-enable latch itself. The front end decodes instructions and hands this unit one-cycle strobes: set-enable, clear-enable, status write (with its data byte), a per-byte memory write request with its address, the end of a write instruction, and the end of any special nonvolatile command (store, recall, automatic-store enable or disable).

For each memory byte the unit answers with a combinational grant in the same cycle, so the front end can commit or silently drop the byte while its burst address keeps advancing. For each status write it answers with a grant and applies the change on the next clock edge. The write-enable latch clears itself once any write-type instruction completes, so every write instruction must be preceded by a fresh set-enable. An active-low hardware protect pin, together with the protect-enable bit, locks the status byte.

Top module: `wprot_unit`

## Requirements
- R1: A set-enable strobe makes status bit 1 (write-enable latch) read 1 from the next cycle; a clear-enable strobe makes it read 0 from the next cycle.
- R2: The write-enable latch reads 0 in the cycle after a write-end strobe, a status-write strobe (granted or not) or a special-command strobe.
- R3: A memory byte write is granted in the same cycle only if the write-enable latch is 1, the busy input is low and the address is outside the protected range.
- R4: Block-protect field at status bits 3:2: 00 protects nothing, 01 protects 0x18000 to 0x1FFFF, 10 protects 0x10000 to 0x1FFFF, 11 protects every address.
- R5: Within one write instruction the latch stays 1 across any number of byte requests, granted or denied, until the write-end strobe.
- R6: A status write is granted when the latch is 1, busy is low, and not (protect-enable is 1 and the protect pin is low); on grant, status bits 7, 3 and 2 take data bits 7, 3 and 2 on the next cycle, and the other data bits have no effect.
- R7: A status write that is not granted leaves status bits 7 to 2 unchanged while still clearing the latch.
- R8: The status byte reads protect-enable at bit 7, zeros at bits 6 to 4, the protect field at bits 3:2, the latch at bit 1 and, at bit 0, the busy input of the same cycle.
- R9: While the busy input is high, neither memory writes nor status writes are granted.
- R10: After reset the status byte reads 0 apart from bit 0, which follows busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Set-enable instruction strobe |
| wrdi_i | input | 1 | Clear-enable instruction strobe |
| sr_wr_i | input | 1 | Status-write instruction strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| special_i | input | 1 | Special nonvolatile command completed |
| mem_req_i | input | 1 | Memory byte write request |
| mem_addr_i | input | ADDR_W | Address of the byte write |
| mem_end_i | input | 1 | Write instruction completed |
| busy_i | input | 1 | Store or recall in progress |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| mem_grant_o | output | 1 | Byte write may be committed |
| sr_grant_o | output | 1 | Status write accepted |
| status_o | output | 8 | Status byte for reads |

## Verification
The bench walks each protect setting across the exact boundary addresses 0x0FFFF/0x10000, 0x17FFF/0x18000 and the top address; a design with the quarter and half decodes swapped, or an off-by-one range, grants a byte it should drop. It runs a burst that crosses into the protected quarter and then issues a byte after write-end, which catches a latch cleared per byte rather than per instruction, or never cleared at all. It attempts a status write with the pin low and protect-enable set and checks that the protect bits stay but the latch still drops, and it raises busy with the latch set to catch a grant that ignores busy. Status writes with all-ones data catch a design that lets bits 6 to 4 or bit 0 be written.

// File: rtl/wprot_unit.sv
module wprot_unit #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              special_i,
  input  logic              mem_req_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              mem_end_i,
  input  logic              busy_i,
  input  logic              wp_n_i,
  output logic              mem_grant_o,
  output logic              sr_grant_o,
  output logic [7:0]        status_o
);

  logic       wen_q;
  logic       wpen_q;
  logic [1:0] bp_q;
  logic       in_prot;
  logic       sr_locked;
  logic       wen_clr;

  always_comb begin
    case (bp_q)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = &mem_addr_i[ADDR_W-1:ADDR_W-2];
      2'b10:   in_prot = mem_addr_i[ADDR_W-1];
      default: in_prot = 1'b1;
    endcase
  end

  assign sr_locked   = wpen_q & ~wp_n_i;
  assign mem_grant_o = mem_req_i & wen_q & ~busy_i & ~in_prot;
  assign sr_grant_o  = sr_wr_i & wen_q & ~busy_i & ~sr_locked;
  assign wen_clr     = mem_end_i | sr_wr_i | special_i | wrdi_i;
  assign status_o    = {wpen_q, 3'b000, bp_q, wen_q, busy_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (wen_clr) begin
      wen_q <= 1'b0;
    end else if (wren_i) begin
      wen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (sr_grant_o) begin
      wpen_q <= sr_data_i[7];
      bp_q   <= sr_data_i[3:2];
    end
  end

  p_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_i, wrdi_i, sr_wr_i, special_i, mem_end_i}));

  p_wren_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wren_i |=> status_o[1]);

  p_wrdi_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_i |=> !status_o[1]);

  p_auto_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_end_i || sr_wr_i || special_i) |=> !status_o[1]);

  p_grant_needs_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_o |-> status_o[1]);

  p_full_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !mem_grant_o);

  p_burst_keeps_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_i && status_o[1]) |=> status_o[1]);

  p_sr_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |=> (status_o[7] == $past(sr_data_i[7])) && (status_o[3:2] == $past(sr_data_i[3:2])));

  p_sr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !sr_grant_o) |=> $stable(status_o[7:2]));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (!mem_grant_o && !sr_grant_o));

endmodule

// File: tb/wprot_unit_tb.sv
module wprot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wren_i = 0, wrdi_i = 0, sr_wr_i = 0, special_i = 0;
  logic        mem_req_i = 0, mem_end_i = 0, busy_i = 0, wp_n_i = 1;
  logic [7:0]  sr_data_i = 0;
  logic [16:0] mem_addr_i = 0;
  logic        mem_grant_o, sr_grant_o;
  logic [7:0]  status_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";
  bit done = 0;

  bit m_wen = 0, m_wpen = 0;
  bit [1:0] m_bp = 0;

  always #5 clk = ~clk;

  wprot_unit u_dut (.*);

  function automatic bit prot(input bit [1:0] bp, input int addr);
    case (bp)
      0: return 0;
      1: return addr >= 'h18000;
      2: return addr >= 'h10000;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wren, input bit wrdi, input bit srw, input bit [7:0] d,
                     input bit spec, input bit req, input int addr, input bit wend,
                     input bit busy, input bit wpn);
    bit exp_mg, exp_sg;
    wren_i = wren; wrdi_i = wrdi; sr_wr_i = srw; sr_data_i = d; special_i = spec;
    mem_req_i = req; mem_addr_i = addr[16:0]; mem_end_i = wend; busy_i = busy; wp_n_i = wpn;
    #1;
    exp_mg = req && m_wen && !busy && !prot(m_bp, addr);
    exp_sg = srw && m_wen && !busy && !(m_wpen && !wpn);
    chk(cur_req, status_o, {m_wpen, 3'b000, m_bp, m_wen, busy}, "status");
    chk(cur_req, mem_grant_o, exp_mg, "mem_grant");
    chk(cur_req, sr_grant_o, exp_sg, "sr_grant");
    @(posedge clk);
    if (exp_sg) begin m_wpen = d[7]; m_bp = d[3:2]; end
    if (wend || srw || spec || wrdi) m_wen = 0;
    else if (wren) m_wen = 1;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,0,1); endtask
  task automatic wren(); cyc(1,0,0,0,0,0,0,0,0,1); endtask
  task automatic wrsr(input bit [7:0] d, input bit wpn); cyc(0,0,1,d,0,0,0,0,0,wpn); endtask
  task automatic mwr(input int a); cyc(0,0,0,0,0,1,a,0,0,1); endtask
  task automatic mend(); cyc(0,0,0,0,0,0,0,1,0,1); endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int addrs[6] = '{'h00000, 'h0FFFF, 'h10000, 'h17FFF, 'h18000, 'h1FFFF};
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cur_req = "R10"; idle();
    cur_req = "R1"; wren(); idle(); cyc(0,1,0,0,0,0,0,0,0,1); idle();
    cur_req = "R6"; wren(); wrsr(8'hFF, 1); idle();
    cur_req = "R8"; wren(); wrsr(8'h73, 1); idle();
    cur_req = "R7"; wren(); wrsr(8'hFC, 1); wren(); wrsr(8'h00, 0); idle();
    wren(); wrsr(8'h00, 1); idle();
    cur_req = "R4";
    for (int bp = 0; bp < 4; bp++) begin
      wren(); wrsr(8'(bp << 2), 1);
      wren();
      foreach (addrs[i]) mwr(addrs[i]);
      mend();
    end
    cur_req = "R5";
    wren(); wrsr(8'h04, 1); wren();
    mwr('h17FFE); mwr('h17FFF); mwr('h18000); mwr('h18001); mwr('h00002);
    cur_req = "R2"; mend(); mwr('h00003); idle();
    wren(); cyc(0,0,0,0,1,0,0,0,0,1); idle();
    cur_req = "R3"; mwr('h00010); wren(); mwr('h00010); mend();
    cur_req = "R9"; wren();
    cyc(0,0,0,0,0,1,'h10,0,1,1);
    cyc(0,0,1,8'h00,0,0,0,0,1,1);
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule